// File: doc/BRIEF.md
# BCD Calendar Clock with Host Freeze

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours (24-hour), day of week, date, month, a two-digit year and a separate century byte. An external pulse, one cycle wide per second (or held high for several cycles to step quickly), advances the count. Calendar rules are applied, including month lengths and a leap day in every year divisible by four.

The host reaches the fields through a byte-wide register port with a 4-bit address and separate read and write strobes. A freeze bit in the control byte lets software take a consistent snapshot. While the bit is clear, the visible copy holds still and the internal count keeps running. To set the clock, software clears the bit, writes the fields it wants, and sets the bit again. The written values are then loaded into the counter in one step. If nothing was written while frozen, setting the bit only lets the visible copy catch up with the running count.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x00, date 0x01, month 0x01, year 0x00, century 0x20, and the control byte at address 0xF reads 0x80.
- R2: The field addresses are 0x0 seconds, 0x1 minutes, 0x2 hours, 0x3 day of week, 0x4 date, 0x5 month, 0x6 year and 0x7 century. Written bits outside a field's width read back as 0. The widths are 7 bits for seconds and minutes, 6 bits for hours and date, 5 bits for month, 3 bits for day of week, and 8 bits for year and century.
- R3: On a tick, seconds and minutes wrap from 0x59 to 0x00 and carry into the next field. Hours wrap from 0x23 to 0x00 and carry into the date.
- R4: The date wraps to 0x01 after the last day of the month. That day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, 0x31 for the other months, and 0x29 or 0x28 for month 0x02 depending on whether the year is divisible by four. Month 0x12 wraps to 0x01 and carries into the year.
- R5: Year 0x99 wraps to 0x00 and increments the century in BCD.
- R6: Day of week is a 3-bit count that increments at each day rollover, with 7 wrapping to 0.
- R7: While control bit 7 (the freeze bit, where 1 means running) is 0, reads return the frozen values while the internal count keeps advancing. Setting the bit with no field write in between makes reads show the advanced count.
- R8: Field writes made while the bit is 0 are read back while frozen. When the bit is next written to 1, they are loaded into the counter, and counting continues from them.
- R9: Writes to addresses 0x0 to 0x7 while the bit is 1 leave the time fields unchanged.
- R10: The month byte's bits 7:5 are plain storage. They take the written value on every write to 0x5, whatever the freeze bit, and read back beside the month field.
- R11: The read data register changes only on the cycle after a read strobe and holds otherwise. Addresses 0x8 to 0xE read 0x00.
- R12: The count advances one second for each cycle in which the tick input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | Advance one second per high cycle |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |

## Verification
A wrong carry chain shows at the ports on the first rollover that uses it. Because the visible copy trails the counter by one cycle, a read issued two cycles after the tick already shows the error. A freeze or load fault is subtler: reads during the freeze still look right, but the count reported after the freeze bit is set again is off. The bench therefore always reads back after re-enabling. A corrupt leap or month-length decode stays hidden until the end of a month, so the directed cases start one second before each such boundary.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_time_t;

  localparam logic [7:0] SEC_TOP = 8'h59;
  localparam logic [7:0] MIN_TOP = 8'h59;
  localparam logic [7:0] HR_TOP  = 8'h23;
  localparam logic [7:0] MON_TOP = 8'h12;
  localparam logic [7:0] YR_TOP  = 8'h99;

  localparam cal_time_t CAL_RST_DEFAULT = '{cen: 8'h20, yr: 8'h00, mon: 5'h01,
                                            date: 6'h01, dow: 3'd0, hr: 6'h00,
                                            min: 7'h00, sec: 7'h00};

  // Packed BCD increment of a two-digit value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Step a field: at or past its top value it returns to base.
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] base);
    if (v >= top) return base;
    return bcd_inc(v);
  endfunction

  // A BCD year is divisible by four when an even tens digit meets 0/4/8
  // or an odd tens digit meets 2/6.
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_len(input logic [4:0] m,
                                           input logic [7:0] y);
    case (m)
      5'h02: return is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_time_counter.sv
`timescale 1ns/1ps
module cal_time_counter
  import cal_pkg::*;
#(
  parameter cal_time_t RST_TIME = CAL_RST_DEFAULT
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load_req,
  input  cal_time_t load_val,
  output cal_time_t cnt,
  output logic      sec_wrap,
  output logic      day_wrap,
  output logic      yr_wrap
);

  logic       adv, min_wrap, hr_wrap, date_wrap, mon_wrap;
  logic [7:0] s8, m8, h8, d8, mo8, dim;
  cal_time_t  nxt;

  always_comb begin
    adv       = tick && !load_req;
    dim       = month_len(cnt.mon, cnt.yr);
    sec_wrap  = adv       && ({1'b0, cnt.sec}  >= SEC_TOP);
    min_wrap  = sec_wrap  && ({1'b0, cnt.min}  >= MIN_TOP);
    hr_wrap   = min_wrap  && ({2'b0, cnt.hr}   >= HR_TOP);
    day_wrap  = hr_wrap;
    date_wrap = day_wrap  && ({2'b0, cnt.date} >= dim);
    mon_wrap  = date_wrap && ({3'b0, cnt.mon}  >= MON_TOP);
    yr_wrap   = mon_wrap  && (cnt.yr >= YR_TOP);

    s8  = bcd_step({1'b0, cnt.sec},  SEC_TOP, 8'h00);
    m8  = bcd_step({1'b0, cnt.min},  MIN_TOP, 8'h00);
    h8  = bcd_step({2'b0, cnt.hr},   HR_TOP,  8'h00);
    d8  = bcd_step({2'b0, cnt.date}, dim,     8'h01);
    mo8 = bcd_step({3'b0, cnt.mon},  MON_TOP, 8'h01);

    nxt = cnt;
    if (adv)      nxt.sec  = s8[6:0];
    if (sec_wrap) nxt.min  = m8[6:0];
    if (min_wrap) nxt.hr   = h8[5:0];
    if (day_wrap) begin
      nxt.date = d8[5:0];
      nxt.dow  = cnt.dow + 3'd1;
    end
    if (date_wrap) nxt.mon = mo8[4:0];
    if (mon_wrap)  nxt.yr  = bcd_step(cnt.yr, YR_TOP, 8'h00);
    if (yr_wrap)   nxt.cen = bcd_step(cnt.cen, YR_TOP, 8'h00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= RST_TIME;
    else if (load_req) cnt <= load_val;
    else               cnt <= nxt;
  end

endmodule

// File: rtl/cal_host_regs.sv
`timescale 1ns/1ps
module cal_host_regs
  import cal_pkg::*;
#(
  parameter int        ADDR_W   = 4,
  parameter int        DATA_W   = 8,
  parameter cal_time_t RST_TIME = CAL_RST_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  cal_time_t         cnt,
  output cal_time_t         usr,
  output logic              te,
  output logic              time_wr,
  output logic              load_req,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DOW  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_CEN  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(15);
  localparam int TE_BIT = DATA_W - 1;

  logic       dirty;
  logic [2:0] mon_hi;
  logic       ctrl_wr;

  always_comb begin
    time_wr  = wr && (addr <= A_CEN);
    ctrl_wr  = wr && (addr == A_CTRL);
    load_req = ctrl_wr && wdata[TE_BIT] && !te && dirty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usr    <= RST_TIME;
      te     <= 1'b1;
      dirty  <= 1'b0;
      mon_hi <= 3'd0;
    end else begin
      if (ctrl_wr) begin
        te <= wdata[TE_BIT];
        if (wdata[TE_BIT] && !te) dirty <= 1'b0;
      end
      if (wr && addr == A_MON) mon_hi <= wdata[7:5];
      if (te) begin
        usr <= cnt;
      end else if (time_wr) begin
        dirty <= 1'b1;
        case (addr)
          A_SEC:  usr.sec  <= wdata[6:0];
          A_MIN:  usr.min  <= wdata[6:0];
          A_HR:   usr.hr   <= wdata[5:0];
          A_DOW:  usr.dow  <= wdata[2:0];
          A_DATE: usr.date <= wdata[5:0];
          A_MON:  usr.mon  <= wdata[4:0];
          A_YR:   usr.yr   <= wdata;
          default: usr.cen <= wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        A_SEC:  rdata <= {1'b0, usr.sec};
        A_MIN:  rdata <= {1'b0, usr.min};
        A_HR:   rdata <= {2'b0, usr.hr};
        A_DOW:  rdata <= {5'b0, usr.dow};
        A_DATE: rdata <= {2'b0, usr.date};
        A_MON:  rdata <= {mon_hi, usr.mon};
        A_YR:   rdata <= usr.yr;
        A_CEN:  rdata <= usr.cen;
        A_CTRL: rdata <= {te, 7'b0};
        default: rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/bcd_calendar_clock.sv
`timescale 1ns/1ps
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int        ADDR_W   = 4,
  parameter int        DATA_W   = 8,
  parameter cal_time_t RST_TIME = CAL_RST_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);

  cal_time_t cnt_w, usr_w;
  logic      te_w, time_wr_w, load_req_w;
  logic      sec_wrap_w, day_wrap_w, yr_wrap_w;

  cal_time_counter #(.RST_TIME(RST_TIME)) counter_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .load_req (load_req_w),
    .load_val (usr_w),
    .cnt      (cnt_w),
    .sec_wrap (sec_wrap_w),
    .day_wrap (day_wrap_w),
    .yr_wrap  (yr_wrap_w)
  );

  cal_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_TIME(RST_TIME)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .cnt      (cnt_w),
    .usr      (usr_w),
    .te       (te_w),
    .time_wr  (time_wr_w),
    .load_req (load_req_w),
    .rdata    (reg_rdata)
  );

endmodule

// File: rtl/cal_checker.sv
`timescale 1ns/1ps
module cal_checker
  import cal_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rd,
  input logic [DATA_W-1:0] rdata,
  input logic              te,
  input logic              time_wr,
  input logic              load_req,
  input cal_time_t         cnt,
  input cal_time_t         usr,
  input logic              sec_wrap,
  input logic              day_wrap,
  input logic              yr_wrap
);

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_wrap && !load_req) |-> (cnt.sec == 7'h00));

  assert_century_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(yr_wrap && !load_req) |-> (cnt.yr == 8'h00 && cnt.mon == 5'h01 && cnt.date == 6'h01));

  assert_dow_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(day_wrap && !load_req) |-> (cnt.dow == $past(cnt.dow) + 3'd1));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!te) && !$past(time_wr)) |-> $stable(usr));

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(te) |-> (usr == $past(cnt)));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_req) |-> (cnt == $past(usr)));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd) |-> $stable(rdata));

  assert_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tick && !load_req) |-> $stable(cnt));

endmodule

bind bcd_calendar_clock cal_checker #(.DATA_W(DATA_W)) checker_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (sec_tick),
  .rd       (reg_rd),
  .rdata    (reg_rdata),
  .te       (te_w),
  .time_wr  (time_wr_w),
  .load_req (load_req_w),
  .cnt      (cnt_w),
  .usr      (usr_w),
  .sec_wrap (sec_wrap_w),
  .day_wrap (day_wrap_w),
  .yr_wrap  (yr_wrap_w)
);

// File: tb/bcd_calendar_clock_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic tick_once();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, dt, w, h, m, s);
    wr(4'hF, 8'h00);
    wr(4'h7, c); wr(4'h6, y); wr(4'h5, mo); wr(4'h4, dt);
    wr(4'h2, h); wr(4'h1, m); wr(4'h0, s); wr(4'h3, w);
    wr(4'hF, 8'h80);
  endtask

  task automatic expect_all(input string tag, input logic [7:0] c, y, mo, dt, w, h, m, s);
    expect_reg({tag, " sec"},  4'h0, s);
    expect_reg({tag, " min"},  4'h1, m);
    expect_reg({tag, " hour"}, 4'h2, h);
    expect_reg({tag, " dow"},  4'h3, w);
    expect_reg({tag, " date"}, 4'h4, dt);
    expect_reg({tag, " mon"},  4'h5, mo);
    expect_reg({tag, " year"}, 4'h6, y);
    expect_reg({tag, " cen"},  4'h7, c);
  endtask

  task automatic t_reset();
    expect_all("R1 R2 reset", 8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    expect_reg("R1 ctrl", 4'hF, 8'h80);
  endtask

  task automatic t_hour_carry();
    set_time(8'h20, 8'h25, 8'h06, 8'h10, 8'h01, 8'h09, 8'h59, 8'h59);
    tick_once();
    expect_all("R3 R8 hour carry", 8'h20, 8'h25, 8'h06, 8'h10, 8'h01, 8'h10, 8'h00, 8'h00);
  endtask

  task automatic t_feb_plain();
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    tick_once();
    expect_reg("R3 R8 sec step", 4'h0, 8'h59);
    tick_once();
    expect_all("R4 R6 feb non-leap", 8'h20, 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_feb_leap();
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg("R4 leap date29", 4'h4, 8'h29);
    expect_reg("R4 leap mon", 4'h5, 8'h02);
    expect_reg("R6 dow step", 4'h3, 8'h04);
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg("R4 leap end date", 4'h4, 8'h01);
    expect_reg("R4 leap end mon", 4'h5, 8'h03);
  endtask

  task automatic t_april();
    set_time(8'h20, 8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_reg("R4 30-day date", 4'h4, 8'h01);
    expect_reg("R4 30-day mon", 4'h5, 8'h05);
  endtask

  task automatic t_century();
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    tick_once();
    expect_all("R5 century", 8'h21, 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_freeze();
    set_time(8'h20, 8'h24, 8'h03, 8'h15, 8'h02, 8'h10, 8'h20, 8'h30);
    wr(4'hF, 8'h00);
    tick_once(); tick_once(); tick_once();
    expect_reg("R7 frozen sec", 4'h0, 8'h30);
    expect_reg("R7 ctrl clear", 4'hF, 8'h00);
    wr(4'hF, 8'h80);
    expect_reg("R7 resumed sec", 4'h0, 8'h33);
  endtask

  task automatic t_burst();
    @(negedge clk); sec_tick = 1'b1;
    repeat (5) @(negedge clk);
    sec_tick = 1'b0;
    expect_reg("R12 five ticks", 4'h0, 8'h38);
  endtask

  task automatic t_ignore();
    wr(4'h0, 8'h05);
    expect_reg("R9 sec write ignored", 4'h0, 8'h38);
    wr(4'h5, 8'hE9);
    expect_reg("R9 R10 month field kept, high bits stored", 4'h5, 8'hE3);
  endtask

  task automatic t_mask();
    wr(4'hF, 8'h00);
    wr(4'h2, 8'hE3);
    wr(4'h3, 8'hFE);
    expect_reg("R2 R8 hour mask frozen", 4'h2, 8'h23);
    expect_reg("R2 R8 dow mask frozen", 4'h3, 8'h06);
    wr(4'hF, 8'h80);
    expect_reg("R8 hour loaded", 4'h2, 8'h23);
    expect_reg("R8 dow loaded", 4'h3, 8'h06);
    expect_reg("R10 month high bits kept", 4'h5, 8'hE3);
  endtask

  task automatic t_rdata();
    expect_reg("R11 ctrl read", 4'hF, 8'h80);
    repeat (4) @(negedge clk);
    chk("R11 rdata hold", reg_rdata, 8'h80);
    expect_reg("R11 unmapped", 4'hA, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hour_carry();
    t_feb_plain();
    t_feb_leap();
    t_april();
    t_century();
    t_freeze();
    t_burst();
    t_ignore();
    t_mask();
    t_rdata();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule